// File: doc/BRIEF.md
# Serial Register-Access Bus Master

This block lets on-chip logic perform single register reads and writes on a remote slave. The two ends are joined by one serial line in each direction, and both ends run from the same clock. A request enters on a parallel port. It carries a read/write flag, a size code, a 28-bit address and, for writes, the data. The master accepts the request only when it is idle. It shifts the request out bit by bit, framed by a leading start bit and a trailing parity bit.

After the request the master listens on its input line for the slave's answer. A read answer brings back the data followed by a parity bit. A write answer is a single acknowledge bit. The master reports the outcome with a one-cycle done pulse. It also provides an error flag for a bad parity or a refused write, a timeout flag for a slave that never answered, and the read data right-aligned in a 64-bit word. The response wait is bounded by a programmable cycle count. Reset is asynchronous and active low, and its release must be synchronous to the clock.

Top module: `sra_master`

## Requirements
- R1: While reset is asserted and right after it is released, the outgoing line is 0, the request port is ready, and done, err, timeout and rdata are all 0.
- R2: An accepted request is sent in this order, one bit per clock. First comes a start bit of 1. Then the 3-bit command goes out most significant bit first: bit 2 is 1 for a read and 0 for a write, and bits 1:0 hold the size code c, meaning 2^c bytes. The 28-bit address follows, most significant bit first. The line returns to 0 in the cycle after the parity bit and stays 0 while idle.
- R3: A write places its data field between the address and the parity bit. The field holds the low 8<<c bits of the write data, most significant bit first. A read sends no data field.
- R4: The request parity bit is the XOR of a constant 1 with the three command bits and the 28 address bits. The write data does not enter into it.
- R5: req_ready is 1 only while the master is idle. A req_valid raised while req_ready is 0 starts no second frame.
- R6: A read response is a start bit of 1, followed by 8<<c data bits, most significant first, and then a parity bit. On done, rdata holds those bits right-aligned, and every bit above them is 0.
- R7: For a read, if the response parity bit differs from the XOR of a constant 1 with all returned data bits, err is 1 together with done.
- R8: A write response is a start bit of 1 followed by one acknowledge bit. An acknowledge of 1 gives done with err 0. An acknowledge of 0 gives done with err 1.
- R9: Let L be tmo_limit, with L of at least 1. The cycles after the request ends are sampled in turn. If the response start bit is not seen within the first L of them, done and timeout rise exactly L+1 cycles after the cycle that carried the request parity bit. A start bit seen in cycle L is still accepted.
- R10: The input line is ignored outside the response wait. A response that arrives after a timeout produces no done.
- R11: done lasts one cycle. err and timeout are 1 only while done is 1. After a write or a timeout, rdata reads 0, and it keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for master and slave |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request taken when req_valid is also 1 |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_size | input | 2 | Size code c, 2^c bytes |
| req_addr | input | 28 | Register address |
| req_wdata | input | 64 | Write data, right-aligned |
| tmo_limit | input | 16 | Response wait limit in cycles, held stable during a request |
| tx_line | output | 1 | Serial line toward the slave |
| rx_line | input | 1 | Serial line from the slave |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Parity mismatch or refused write, valid with done |
| timeout | output | 1 | No response in time, valid with done |
| rdata | output | 64 | Read data, right-aligned |

## Verification
The bench sets the response delay to L-1 and then to L cycles. A design with the timer boundary off by one would either time out on a valid response or accept a late one. Read data comes back with junk in the bits above each size, so a design that misaligns or fails to mask would show the junk in rdata. A corrupted read parity and a refused write must each raise err. A slave that answers after a timeout must draw no done, which catches a master that keeps listening after it gives up. Requests raised while the master is busy must not start a second frame. A design that folded the write data into the request parity would be caught by the slave model's parity check.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;
  // width of the command field: read flag plus 2-bit size code
  localparam int CMD_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } mst_state_e;
endpackage

// File: rtl/sra_tx.sv
`timescale 1ns/1ps
module sra_tx
  import sra_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rd,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ser_out,
  output logic              busy,
  output logic              last
);
  localparam int HDR_W = 1 + CMD_W + ADDR_W;
  localparam int PAY_W = DATA_W + 1;
  localparam int FRM_W = HDR_W + PAY_W;
  localparam int CNT_W = $clog2(FRM_W + 1);

  logic [FRM_W-1:0] frm_q, frm_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             busy_q, busy_d;
  logic             ser_q, ser_d;

  logic [CNT_W-1:0] dlen_c;
  logic             par_c;
  logic [HDR_W-1:0] hdr_c;
  logic [PAY_W-1:0] pay_c;

  // frame composition: header, size-trimmed data, parity packed to the top
  always_comb begin
    dlen_c = rd ? '0 : (CNT_W'(8) << size);
    par_c  = ~(^{rd, size, addr});
    hdr_c  = {1'b1, rd, size, addr};
    pay_c  = {wdata, par_c} << (CNT_W'(DATA_W) - dlen_c);
  end

  always_comb begin
    frm_d  = frm_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    ser_d  = ser_q;
    if (!busy_q) begin
      if (load) begin
        frm_d  = {hdr_c, pay_c} << 1;
        rem_d  = CNT_W'(HDR_W) + dlen_c;
        busy_d = 1'b1;
        ser_d  = 1'b1;
      end
    end else if (rem_q == '0) begin
      busy_d = 1'b0;
      ser_d  = 1'b0;
    end else begin
      ser_d = frm_q[FRM_W-1];
      frm_d = frm_q << 1;
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      frm_q  <= frm_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
      ser_q  <= ser_d;
    end
  end

  assign ser_out = ser_q;
  assign busy    = busy_q;
  assign last    = busy_q && (rem_q == '0);

  // R2: every frame opens with a 1 on the line
  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ser_q);
endmodule

// File: rtl/sra_rx.sv
`timescale 1ns/1ps
module sra_rx #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [1:0]        size,
  input  logic              ser_in,
  output logic              busy,
  output logic              fin,
  output logic              fin_err,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              par_q, par_d;
  logic              busy_q, busy_d;
  logic              rd_q, rd_d;

  always_comb begin
    acc_d  = acc_q;
    rem_d  = rem_q;
    par_d  = par_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    if (!busy_q) begin
      if (start) begin
        acc_d  = '0;
        par_d  = 1'b0;
        rem_d  = rd ? (CNT_W'(8) << size) : '0;
        busy_d = 1'b1;
        rd_d   = rd;
      end
    end else if (rem_q == '0) begin
      busy_d = 1'b0;
    end else begin
      acc_d = {acc_q[DATA_W-2:0], ser_in};
      par_d = par_q ^ ser_in;
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      par_q  <= 1'b0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      rem_q  <= rem_d;
      par_q  <= par_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
    end
  end

  // final bit: parity for reads (expected 1 ^ data xor), acknowledge for writes
  assign busy    = busy_q;
  assign fin     = busy_q && (rem_q == '0);
  assign fin_err = rd_q ? ~(ser_in ^ par_q) : ~ser_in;
  assign data    = acc_q;

  // R10: the line has no effect on the accumulator outside a response
  p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(acc_q));
endmodule

// File: rtl/sra_timer.sv
`timescale 1ns/1ps
module sra_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam int CW = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + TMO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (({1'b0, cnt_q} + CW'(1)) >= {1'b0, limit});

  // R9: a running count never passes the limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((cnt_q < limit) || (limit == '0)));
endmodule

// File: rtl/sra_master.sv
`timescale 1ns/1ps
module sra_master
  import sra_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 64,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              tx_line,
  input  logic              rx_line,
  output logic              done,
  output logic              err,
  output logic              timeout,
  output logic [DATA_W-1:0] rdata
);
  mst_state_e        state_q, state_d;
  logic              rd_q, rd_d;
  logic [1:0]        size_q, size_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              tmo_q, tmo_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic              tx_load, tx_busy, tx_last;
  logic              rx_start, rx_busy, rx_fin, rx_err;
  logic [DATA_W-1:0] rx_data;
  logic              tmr_clear, tmr_run, tmr_hit;

  sra_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tx_load),
    .rd      (req_rd),
    .size    (req_size),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .ser_out (tx_line),
    .busy    (tx_busy),
    .last    (tx_last)
  );

  sra_rx #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (rx_start),
    .rd      (rd_q),
    .size    (size_q),
    .ser_in  (rx_line),
    .busy    (rx_busy),
    .fin     (rx_fin),
    .fin_err (rx_err),
    .data    (rx_data)
  );

  sra_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .limit  (tmo_limit),
    .expire (tmr_hit)
  );

  assign tmr_clear = (state_q != ST_WAIT);
  assign tmr_run   = (state_q == ST_WAIT) && !rx_line;

  always_comb begin
    state_d  = state_q;
    rd_d     = rd_q;
    size_d   = size_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    tmo_d    = 1'b0;
    rdata_d  = rdata_q;
    tx_load  = 1'b0;
    rx_start = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tx_load = 1'b1;
          rd_d    = req_rd;
          size_d  = req_size;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (tx_last) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rx_line) begin
          rx_start = 1'b1;
          state_d  = ST_RECV;
        end else if (tmr_hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          tmo_d   = 1'b1;
          rdata_d = '0;
        end
      end
      ST_RECV: begin
        if (rx_fin) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = rx_err;
          rdata_d = rd_q ? rx_data : '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      size_q  <= 2'd0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      size_q  <= size_d;
      done_q  <= done_d;
      err_q   <= err_d;
      tmo_q   <= tmo_d;
      rdata_q <= rdata_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign timeout   = tmo_q;
  assign rdata     = rdata_q;

  // R2: the line rests low whenever no request is in flight
  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !tx_line);

  // R5: taking a request drops ready on the next cycle
  p_one_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6: read data never carries bits above the requested size
  p_rdata_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && rd_q && !tmo_q) |-> ((rdata_q >> (8 << size_q)) == '0));

  // R7 and R8: an error is only reported with a completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);

  // R9: timeout comes with done and never with err
  p_tmo_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (done_q && !err_q));

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: the receiver is only started while waiting
  p_rx_only_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !$past(rx_busy)) |-> ($past(state_q) == ST_WAIT));
endmodule

// File: tb/sra_master_bench.sv
`timescale 1ns/1ps
module sra_master_bench;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 64;
  localparam int TMO_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_rd;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [TMO_W-1:0]  tmo_limit;
  logic              tx_line, rx_line;
  logic              done, err, timeout;
  logic [DATA_W-1:0] rdata;

  always #4 clk = ~clk;   // 125 MHz

  sra_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_sra_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .tmo_limit(tmo_limit), .tx_line(tx_line), .rx_line(rx_line),
    .done(done), .err(err), .timeout(timeout), .rdata(rdata)
  );

  typedef struct {
    logic [63:0] rdata;
    bit          err;
    bit          tmo;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   done_cnt = 0;
  int   done_cyc = 0;
  int   par_cyc = 0;
  int   frames = 0;

  // slave model configuration and capture
  int          s_gap = 2;
  bit          s_silent = 0;
  bit          s_bad_par = 0;
  bit          s_nack = 0;
  logic [63:0] s_rdata = '0;
  bit          s_busy = 0;
  logic [2:0]  exp_cmd;
  logic [27:0] exp_addr;
  logic [63:0] exp_wdata;
  logic [2:0]  sc;
  logic [27:0] sa;
  logic [63:0] sd;
  logic        sp, px;
  int          sdl, rl;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(0, "R10", "completion with nothing outstanding", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rdata == e.rdata, "R6", {e.tag, " rdata"}, rdata, e.rdata);
          chk(err == e.err, "R7", {e.tag, " err"}, 64'(err), 64'(e.err));
          chk(timeout == e.tmo, "R9", {e.tag, " timeout"}, 64'(timeout), 64'(e.tmo));
        end
        done_cnt++;
        done_cyc = cyc;
      end else if (err || timeout) begin
        chk(0, "R11", "flag without done", {62'd0, err, timeout}, 64'd0);
      end
    end
  end

  // slave model: decodes the request frame and answers it
  initial begin : slave
    rx_line = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && tx_line) begin
        s_busy = 1;
        sc = '0; sa = '0; sd = '0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); sc = {sc[1:0], tx_line}; end
        for (int i = 0; i < ADDR_W; i++) begin @(negedge clk); sa = {sa[ADDR_W-2:0], tx_line}; end
        sdl = sc[2] ? 0 : (8 << sc[1:0]);
        for (int i = 0; i < sdl; i++) begin @(negedge clk); sd = {sd[62:0], tx_line}; end
        @(negedge clk);
        sp = tx_line;
        par_cyc = cyc;
        frames++;
        chk(sc == exp_cmd, "R2", "command field", 64'(sc), 64'(exp_cmd));
        chk(sa == exp_addr, "R2", "address field", 64'(sa), 64'(exp_addr));
        chk(sd == exp_wdata, "R3", "write data field", sd, exp_wdata);
        chk(sp == ~(^{sc, sa}), "R4", "request parity", 64'(sp), 64'(~(^{exp_cmd, exp_addr})));
        @(negedge clk);
        chk(tx_line == 1'b0, "R2", "line low after parity", 64'(tx_line), 64'd0);
        repeat (s_gap - 1) @(negedge clk);
        if (!s_silent) begin
          @(negedge clk); rx_line = 1'b1;
          if (sc[2]) begin
            rl = 8 << sc[1:0];
            px = 1'b0;
            for (int i = rl - 1; i >= 0; i--) begin
              @(negedge clk); rx_line = s_rdata[i]; px = px ^ s_rdata[i];
            end
            @(negedge clk); rx_line = ~px ^ s_bad_par;
          end else begin
            @(negedge clk); rx_line = (sp == ~(^{sc, sa})) && !s_nack;
          end
          @(negedge clk); rx_line = 1'b0;
        end
        s_busy = 0;
      end
    end
  end

  // driver: pushes the expected outcome and issues the request
  task automatic do_req(input bit rd, input logic [1:0] sz, input logic [27:0] a,
                        input logic [63:0] wd, input string tag, input bit poke);
    exp_t        e;
    int          dl;
    logic [63:0] m;
    int          d0;
    int          f0;
    dl = 8 << sz;
    m  = (dl == 64) ? '1 : ((64'd1 << dl) - 64'd1);
    exp_cmd   = {rd, sz};
    exp_addr  = a;
    exp_wdata = rd ? '0 : (wd & m);
    e.tmo   = s_silent || (s_gap >= int'(tmo_limit));
    e.err   = !e.tmo && (rd ? s_bad_par : s_nack);
    e.rdata = (!e.tmo && rd) ? (s_rdata & m) : '0;
    e.tag   = tag;
    sb_q.push_back(e);
    d0 = done_cnt;
    f0 = frames;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_rd = ~rd; req_addr = ~a; req_wdata = ~wd;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R5", {tag, " ready while busy"}, 64'(req_ready), 64'd0);
      end
      req_valid = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R11", {tag, " done single cycle"}, 64'(done), 64'd0);
    if (e.tmo)
      chk(done_cyc - par_cyc == int'(tmo_limit) + 1, "R9", {tag, " timeout latency"},
          64'(done_cyc - par_cyc), 64'(int'(tmo_limit) + 1));
    while (s_busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", {tag, " one completion only"}, 64'(done_cnt - d0), 64'd1);
    chk(frames == f0 + 1, "R5", {tag, " one frame only"}, 64'(frames - f0), 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    req_valid = 1'b0; req_rd = 1'b0; req_size = 2'd0; req_addr = '0; req_wdata = '0;
    tmo_limit = 16'd64;
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b0, "R1", "line in reset", 64'(tx_line), 64'd0);
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    chk({done, err, timeout} == 3'b000, "R1", "flags in reset", 64'({done, err, timeout}), 64'd0);
    chk(rdata == '0, "R1", "rdata in reset", rdata, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_line == 1'b0 && req_ready == 1'b1, "R1", "idle after release",
        64'({tx_line, req_ready}), 64'b01);

    // writes of every size (R3 R4 R8)
    s_gap = 1;
    do_req(1'b0, 2'd0, 28'hABCDEF1, 64'hFFFF_FFFF_FFFF_FF5A, "wr8", 1'b0);
    s_gap = 3;
    do_req(1'b0, 2'd1, 28'h0000001, 64'h1234_5678_9ABC_C3A5, "wr16", 1'b0);
    do_req(1'b0, 2'd2, 28'h8000000, 64'hDEAD_BEEF_0F0F_F0F0, "wr32", 1'b0);
    do_req(1'b0, 2'd3, 28'h5555555, 64'h8000_0000_0000_0001, "wr64", 1'b0);

    // reads of every size with junk above the size (R6)
    s_rdata = 64'hA5A5_5A5A_C3C3_3C96;
    do_req(1'b1, 2'd0, 28'h0FFFFFF, '0, "rd8", 1'b0);
    do_req(1'b1, 2'd1, 28'h1234567, '0, "rd16", 1'b0);
    s_rdata = 64'hFEDC_BA98_8765_4321;
    do_req(1'b1, 2'd2, 28'h7654321, '0, "rd32", 1'b0);
    do_req(1'b1, 2'd3, 28'hFFFFFFF, '0, "rd64", 1'b1);   // also R5 busy poke

    // write after read returns rdata to zero (R11)
    do_req(1'b0, 2'd2, 28'h0000100, 64'h0000_0000_1111_2222, "wr_after_rd_r11", 1'b0);

    // bad read parity (R7) and refused write (R8)
    s_bad_par = 1;
    do_req(1'b1, 2'd1, 28'h00000F0, '0, "rd_badpar_r7", 1'b0);
    s_bad_par = 0;
    s_nack = 1;
    do_req(1'b0, 2'd0, 28'h00000F1, 64'h77, "wr_nack_r8", 1'b0);
    s_nack = 0;

    // timeout window (R9 R10)
    tmo_limit = 16'd20;
    s_silent = 1;
    do_req(1'b1, 2'd2, 28'h0ABCDE0, '0, "silent_r9", 1'b0);
    s_silent = 0;
    s_gap = 19;
    s_rdata = 64'h0000_0000_0000_00C4;
    do_req(1'b1, 2'd0, 28'h0ABCDE1, '0, "last_cycle_start_r9", 1'b0);
    s_gap = 20;
    do_req(1'b0, 2'd3, 28'h0ABCDE2, 64'h0123_4567_89AB_CDEF, "late_response_r10", 1'b0);
    s_gap = 2;
    tmo_limit = 16'd64;
    do_req(1'b1, 2'd3, 28'h0000042, '0, "rd64_after_tmo", 1'b0);

    summary();
    $finish;
  end
endmodule